// File: doc/BRIEF.md
# Memory-to-Memory Expression Tree Unit

This block evaluates one arithmetic or logical expression per run through a fixed three-level tree of operator nodes. All six source operands are read from a byte-addressed data memory reached through a single-port request/grant interface, and the single result is written back to memory. There is no register file: a configuration presented with the `start` pulse gives six operand addresses, a per-operand indirection bit, operator selects for the tree, and a destination address.

The tree is shaped for C-style precedence. Three leaf nodes pair the operands (R0,R1), (R2,R3) and (R4,R5) and perform multiply-class work. A middle node merges the first two leaves with add-class work. A root node combines the middle result with the third leaf. A small state machine sequences the operand reads one per cycle, with an optional pointer read before a data read, then issues the write and pulses `done`.

States: `ST_IDLE` (waiting; `start` moves to `ST_FETCH`), `ST_FETCH` (read request held; grant moves to `ST_WAIT`), `ST_WAIT` (read data captured; back to `ST_FETCH` after a pointer read or when operands remain, otherwise to `ST_WRITE`), `ST_WRITE` (write request held; grant moves to `ST_DONE`), `ST_DONE` (one-cycle completion, then `ST_IDLE`).

Top module: `expr_tree_unit`

## Requirements
- R1: After reset the unit is idle: `busy`, `done`, `mem_req` and `mem_we` are 0.
- R2: Operand k uses address bits `opnd_addr[8k+7:8k]`; with its `opnd_ind` bit k at 0 the byte at that address is the operand, fetched with one read. With the grant always high, `done` is seen 14 clock edges after the edge that samples `start` when no operand is indirect.
- R3: With `opnd_ind` bit k at 1 the byte at the address field is first read as a pointer and the operand is the byte at that pointer; each indirect operand adds exactly 2 cycles to the run.
- R4: Leaf A gives R0*R1 (low 8 bits) when `leaf_sel[0]` is 0 and R0&R1 when it is 1; leaf B does the same on R2,R3 under `leaf_sel[1]`; leaf C always gives R4*R5 (low 8 bits).
- R5: The middle node gives A+B when `mid_sel[0]` is 0 and A-B when 1 (modulo 256); when `mid_sel[1]` is 1 it passes A alone.
- R6: The root takes left = middle output, right = leaf C, with `root_op` codes 0 add, 1 subtract (left-right), 2 AND, 3 OR, 4 XOR, 5 pass left, 6 pass right; codes 7 to 15 pass left.
- R7: Each run writes the result exactly once, to `dest_addr`; `mem_we` is only high together with `mem_req`.
- R8: A request is held with stable address and direction until `mem_gnt` is seen high; withheld grants lengthen a run but do not change its result.
- R9: `done` is a one-cycle pulse in the cycle after the write is granted; `busy` is low in the cycle after `done`.
- R10: `start` while `busy` is high is ignored: it causes no second write and no second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run with the presented configuration (sampled in idle) |
| opnd_addr | input | 48 | Six 8-bit operand address fields, operand k at bits 8k+7:8k |
| opnd_ind | input | 6 | Per-operand indirection bit, bit k for operand k |
| leaf_sel | input | 2 | Bit 0 leaf A, bit 1 leaf B: 0 multiply, 1 AND |
| mid_sel | input | 2 | Bit 0: 0 add, 1 subtract; bit 1: pass leaf A |
| root_op | input | 4 | Root operation code |
| dest_addr | input | 8 | Result address |
| busy | output | 1 | Run in progress |
| done | output | 1 | Completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 8 | Read data, valid the cycle after a granted read |

## Verification
The bench targets mixed direct and indirect operands, where a unit that skipped the pointer read would compute on the pointer byte and finish two cycles early per operand. Subtraction that wraps below zero, reserved root codes and the pass-through selects are exercised, since a wrong default or a sign-extended result would land a different byte at the destination. A grant that is withheld on a repeating pattern checks that the unit neither drops nor re-captures read data, and a `start` pulse mid-run checks that a careless idle test does not launch a second write.

// File: rtl/expr_tree_pkg.sv
package expr_tree_pkg;
    localparam int NUM_OPND = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_WRITE,
        ST_DONE
    } state_t;

    typedef enum logic [3:0] {
        ROOT_ADD   = 4'd0,
        ROOT_SUB   = 4'd1,
        ROOT_AND   = 4'd2,
        ROOT_OR    = 4'd3,
        ROOT_XOR   = 4'd4,
        ROOT_LEFT  = 4'd5,
        ROOT_RIGHT = 4'd6
    } root_op_t;
endpackage

// File: rtl/expr_leaf_node.sv
module expr_leaf_node #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         use_and,
    output logic [W-1:0] y
);
    logic [W-1:0] prod;
    assign prod = a * b;
    assign y    = use_and ? (a & b) : prod;
endmodule

// File: rtl/expr_mid_node.sv
module expr_mid_node #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    input  logic         pass_a,
    output logic [W-1:0] y
);
    logic [W-1:0] sum;
    assign sum = do_sub ? (a - b) : (a + b);
    assign y   = pass_a ? a : sum;
endmodule

// File: rtl/expr_root_node.sv
module expr_root_node
    import expr_tree_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] left,
    input  logic [W-1:0] right,
    input  logic [3:0]   op,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            ROOT_ADD:   y = left + right;
            ROOT_SUB:   y = left - right;
            ROOT_AND:   y = left & right;
            ROOT_OR:    y = left | right;
            ROOT_XOR:   y = left ^ right;
            ROOT_RIGHT: y = right;
            default:    y = left;
        endcase
    end
endmodule

// File: rtl/expr_tree_unit.sv
module expr_tree_unit
    import expr_tree_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [NUM_OPND*ADDR_W-1:0] opnd_addr,
    input  logic [NUM_OPND-1:0]        opnd_ind,
    input  logic [1:0]                 leaf_sel,
    input  logic [1:0]                 mid_sel,
    input  logic [3:0]                 root_op,
    input  logic [ADDR_W-1:0]          dest_addr,
    output logic                       busy,
    output logic                       done,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    input  logic                       mem_gnt,
    input  logic [DATA_W-1:0]          mem_rdata
);
    localparam int IDX_W = $clog2(NUM_OPND);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_OPND - 1);
    localparam int NUM_LEAF = NUM_OPND / 2;

    state_t state_q, state_d;

    logic [ADDR_W-1:0]   addr_q [NUM_OPND];
    logic [NUM_OPND-1:0] ind_q;
    logic [1:0]          leaf_q;
    logic [1:0]          mid_q;
    logic [3:0]          root_q;
    logic [ADDR_W-1:0]   dest_q;
    logic [DATA_W-1:0]   opnd_q [NUM_OPND];
    logic [IDX_W-1:0]    idx_q;
    logic                ptr_phase_q;
    logic [ADDR_W-1:0]   cur_addr_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;
            ST_FETCH: if (mem_gnt) state_d = ST_WAIT;
            ST_WAIT: begin
                if (ptr_phase_q)            state_d = ST_FETCH;
                else if (idx_q == LAST_IDX) state_d = ST_WRITE;
                else                        state_d = ST_FETCH;
            end
            ST_WRITE: if (mem_gnt) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // configuration latch and operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ind_q       <= '0;
            leaf_q      <= '0;
            mid_q       <= '0;
            root_q      <= '0;
            dest_q      <= '0;
            idx_q       <= '0;
            ptr_phase_q <= 1'b0;
            cur_addr_q  <= '0;
            for (int k = 0; k < NUM_OPND; k++) begin
                addr_q[k] <= '0;
                opnd_q[k] <= '0;
            end
        end else if (state_q == ST_IDLE && start) begin
            for (int k = 0; k < NUM_OPND; k++)
                addr_q[k] <= opnd_addr[k*ADDR_W +: ADDR_W];
            ind_q       <= opnd_ind;
            leaf_q      <= leaf_sel;
            mid_q       <= mid_sel;
            root_q      <= root_op;
            dest_q      <= dest_addr;
            idx_q       <= '0;
            ptr_phase_q <= opnd_ind[0];
            cur_addr_q  <= opnd_addr[ADDR_W-1:0];
        end else if (state_q == ST_WAIT) begin
            if (ptr_phase_q) begin
                cur_addr_q  <= mem_rdata[ADDR_W-1:0];
                ptr_phase_q <= 1'b0;
            end else begin
                opnd_q[idx_q] <= mem_rdata;
                if (idx_q != LAST_IDX) begin
                    idx_q       <= idx_q + 1'b1;
                    cur_addr_q  <= addr_q[idx_q + 1'b1];
                    ptr_phase_q <= ind_q[idx_q + 1'b1];
                end
            end
        end
    end

    // operator tree
    logic [DATA_W-1:0]   leaf_y [NUM_LEAF];
    logic [NUM_LEAF-1:0] leaf_and;
    logic [DATA_W-1:0]   mid_y;
    logic [DATA_W-1:0]   root_y;

    assign leaf_and = {1'b0, leaf_q};

    for (genvar g = 0; g < NUM_LEAF; g++) begin : g_leaf
        expr_leaf_node #(.W(DATA_W)) u_leaf (
            .a       (opnd_q[2*g]),
            .b       (opnd_q[2*g+1]),
            .use_and (leaf_and[g]),
            .y       (leaf_y[g])
        );
    end

    expr_mid_node #(.W(DATA_W)) u_mid (
        .a      (leaf_y[0]),
        .b      (leaf_y[1]),
        .do_sub (mid_q[0]),
        .pass_a (mid_q[1]),
        .y      (mid_y)
    );

    expr_root_node #(.W(DATA_W)) u_root (
        .left  (mid_y),
        .right (leaf_y[2]),
        .op    (root_q),
        .y     (root_y)
    );

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        mem_req   = (state_q == ST_FETCH) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = (state_q == ST_WRITE) ? dest_q : cur_addr_q;
        mem_wdata = root_y;
    end
endmodule

// File: rtl/expr_tree_unit_chk.sv
module expr_tree_unit_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));

    a_r7_we_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    a_r8_hold_until_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_gnt) |=> done);

    a_r9_done_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_we && mem_gnt));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

bind expr_tree_unit expr_tree_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/expr_tree_unit_tb.sv
`timescale 1ns/1ps
module expr_tree_unit_tb;
    typedef struct packed {
        logic [5:0] ind;
        logic [1:0] leaf;
        logic [1:0] mid;
        logic [3:0] root;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{6'b000000, 2'b00, 2'b00, 4'd0},
        '{6'b000001, 2'b01, 2'b01, 4'd1},
        '{6'b111111, 2'b10, 2'b10, 4'd2},
        '{6'b000000, 2'b11, 2'b11, 4'd3},
        '{6'b101010, 2'b00, 2'b01, 4'd4},
        '{6'b010000, 2'b01, 2'b00, 4'd5},
        '{6'b000100, 2'b10, 2'b01, 4'd6},
        '{6'b000000, 2'b00, 2'b01, 4'd9},
        '{6'b100001, 2'b11, 2'b00, 4'd15}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] opnd_addr = '0;
    logic [5:0]  opnd_ind = '0;
    logic [1:0]  leaf_sel = '0;
    logic [1:0]  mid_sel = '0;
    logic [3:0]  root_op = '0;
    logic [7:0]  dest_addr = '0;
    logic        busy, done, mem_req, mem_we, mem_gnt;
    logic [7:0]  mem_addr, mem_wdata;
    logic [7:0]  mem_rdata = '0;

    logic [7:0]  mem [256];
    int          wr_cnt = 0;
    int          gcnt = 0;
    bit          stall_en = 1'b0;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    assign mem_gnt = !stall_en || (gcnt % 3 != 0);

    always @(negedge clk) gcnt <= gcnt + 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'((i * 37 + 11) & 255);
        end else if (mem_req && mem_gnt) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr];
            end
        end
    end

    expr_tree_unit u_dut (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fetch(input logic [7:0] a, input logic ind);
        return ind ? mem[mem[a]] : mem[a];
    endfunction

    function automatic logic [7:0] model(input vec_t v, input logic [47:0] adr);
        logic [7:0] r [6];
        logic [7:0] la, lb, lc, m, y;
        for (int k = 0; k < 6; k++) r[k] = fetch(adr[8*k +: 8], v.ind[k]);
        la = v.leaf[0] ? (r[0] & r[1]) : 8'(r[0] * r[1]);   // R4
        lb = v.leaf[1] ? (r[2] & r[3]) : 8'(r[2] * r[3]);
        lc = 8'(r[4] * r[5]);
        m  = v.mid[0] ? 8'(la - lb) : 8'(la + lb);          // R5
        if (v.mid[1]) m = la;
        case (v.root)                                        // R6
            4'd0: y = 8'(m + lc);
            4'd1: y = 8'(m - lc);
            4'd2: y = m & lc;
            4'd3: y = m | lc;
            4'd4: y = m ^ lc;
            4'd6: y = lc;
            default: y = m;
        endcase
        return y;
    endfunction

    task automatic run(input vec_t v, input int seed, input logic [7:0] dst,
                       input bit busy_start, output int lat, output logic [7:0] exp);
        int w0;
        for (int k = 0; k < 6; k++) opnd_addr[8*k +: 8] = 8'(16 * k + seed * 5 + 1);
        @(negedge clk);
        opnd_ind  = v.ind;
        leaf_sel  = v.leaf;
        mid_sel   = v.mid;
        root_op   = v.root;
        dest_addr = dst;
        exp = model(v, opnd_addr);
        w0 = wr_cnt;
        start = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 500) begin
            if (busy_start && lat == 4) begin
                dest_addr = 8'hD0;
                root_op   = 4'd6;
                start     = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        start = 1'b0;
        check("R7 result at destination", mem[dst], exp);
        check("R7 single write", wr_cnt - w0, 1);
        @(negedge clk);
        check("R9 done is a single pulse", done, 0);
        check("R9 busy low after done", busy, 0);
    endtask

    initial begin
        #(8ns * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        logic [7:0] exp;
        logic [7:0] d0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        check("R1 done after reset", done, 0);
        check("R1 mem_req after reset", mem_req, 0);
        check("R1 mem_we after reset", mem_we, 0);
        rst_n = 1'b1;

        // vector table: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            run(VECS[i], i, 8'(8'hE0 + i), 1'b0, lat, exp);
            check("R2 R3 latency", lat, 14 + 2 * $countones(VECS[i].ind));
        end

        // R8: withheld grants, same result as the model
        stall_en = 1'b1;
        run(VECS[2], 2, 8'hF0, 1'b0, lat, exp);
        check("R8 stalled run is longer", int'(lat > 26), 1);
        run(VECS[4], 4, 8'hF1, 1'b0, lat, exp);
        stall_en = 1'b0;

        // R10: start mid-run is ignored
        @(negedge clk);
        d0 = mem[8'hD0];
        run(VECS[1], 3, 8'hF2, 1'b1, lat, exp);
        check("R10 latency unchanged", lat, 16);
        repeat (20) begin
            @(negedge clk);
            if (done || busy) break;
        end
        check("R10 no second run busy", busy, 0);
        check("R10 no second done", done, 0);
        check("R10 other destination untouched", mem[8'hD0], d0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule